// File: doc/BRIEF.md
# Truncated binary code decoder

This block turns one truncated binary (phase-in) code word into the value it stands for. The value is known to lie between 0 and a limit m, and m is given with each code word, so the code length changes from word to word. A neighbouring bit extractor presents a window of stream bits. The window is left-justified: the first stream bit sits at the window's most significant bit. The decoder returns the value and the number of window bits the code used, so the extractor can advance by that amount.

For n = m+1 possible values, let k be the bit length of m and let u = 2^k - n be the threshold. The decoder first reads a short field of k-1 bits. If that field is below u, the field is the value. If it is not, the decoder reads one more bit from directly after the field and subtracts u from the resulting k-bit word. A sample block coded in this mode carries its maximum first, and that maximum is then used as m for every later sample. The decode result is held in one output register behind a valid/ready handshake.

Top module: `tbc_decoder`

## Requirements
- R1: While reset is active and directly after it, valid_o is 0.
- R2: With limit_i = 0, the result is value 0 with 0 bits used, whatever the window holds.
- R3: Let k be the bit length of limit_i and u = 2^k - (limit_i + 1). If the top k-1 window bits, read MSB first, form a number v < u, the result is value v with k-1 bits used.
- R4: Otherwise the top k window bits form w, and the result is value w - u with k bits used.
- R5: When limit_i + 1 is a power of two, u is 0 and every code uses exactly k bits, with value equal to the top k window bits.
- R6: An input is accepted on a rising edge where valid_i and ready_o are both 1. Its result is on value_o and used_o, with valid_o at 1, after that same edge.
- R7: While valid_o is 1 and ready_i is 0, ready_o is 0 and value_o and used_o hold their values. ready_o is 1 whenever the output register is empty or ready_i is 1.
- R8: Window bits below the bits used have no effect on the result.
- R9: Whenever valid_o is 1, value_o does not exceed the limit accepted with it, and used_o does not exceed the value width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Window and limit are valid |
| ready_o | output | 1 | Decoder can accept an input |
| window_i | input | WIN_W | Stream bits, first bit at MSB |
| limit_i | input | VAL_W | Largest value the code can hold (m) |
| valid_o | output | 1 | Result is valid |
| ready_i | input | 1 | Consumer takes the result |
| value_o | output | VAL_W | Decoded value |
| used_o | output | USED_W | Window bits used by the code |

## Verification
A vector table covers several limit shapes. A zero limit tells the empty code apart. Power-of-two ranges show that no short codes exist. Ranges just below a power of two put short and long codes on each side of the threshold. The full 16-bit range probes the width edge. A reference encoder then builds codes for random limits and random values and fills the unused window bits with random noise. Because noise sits in those bits, a decoder that peeks past the code, or that picks the wrong length, returns a different value or count. A stall sequence shows that the result holds and that input is refused until the consumer is ready.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  localparam int unsigned DEF_VAL_W = 16;
  localparam int unsigned DEF_WIN_W = 17;

  typedef enum logic [1:0] {
    CODE_NONE  = 2'd0,
    CODE_SHORT = 2'd1,
    CODE_LONG  = 2'd2
  } code_kind_e;
endpackage

// File: rtl/tbc_width.sv
module tbc_width #(
  parameter int unsigned VAL_W = 16,
  localparam int unsigned KW = $clog2(VAL_W + 1)
) (
  input  logic [VAL_W-1:0] limit_i,
  output logic [KW-1:0]    k_o
);
  // bit length of the limit: ceil(log2(limit+1))
  always_comb begin
    k_o = '0;
    for (int i = 0; i < VAL_W; i++) begin
      if (limit_i[i]) k_o = KW'(i + 1);
    end
  end
endmodule

// File: rtl/tbc_thresh.sv
module tbc_thresh #(
  parameter int unsigned VAL_W = 16,
  localparam int unsigned KW = $clog2(VAL_W + 1)
) (
  input  logic [VAL_W-1:0] limit_i,
  input  logic [KW-1:0]    k_i,
  output logic [VAL_W-1:0] u_o
);
  logic [VAL_W:0] pow_k;
  logic [VAL_W:0] n_val;

  always_comb begin
    pow_k = (VAL_W+1)'(1) << k_i;
    n_val = {1'b0, limit_i} + (VAL_W+1)'(1);
    u_o   = VAL_W'(pow_k - n_val);
  end
endmodule

// File: rtl/tbc_core.sv
module tbc_core
  import tbc_pkg::*;
#(
  parameter int unsigned VAL_W = 16,
  parameter int unsigned WIN_W = 17,
  localparam int unsigned KW = $clog2(VAL_W + 1),
  localparam int unsigned SW = $clog2(WIN_W + 2),
  localparam int unsigned USED_W = $clog2(VAL_W + 1)
) (
  input  logic [WIN_W-1:0]  window_i,
  input  logic [KW-1:0]     k_i,
  input  logic [VAL_W-1:0]  u_i,
  output logic [VAL_W-1:0]  value_o,
  output logic [USED_W-1:0] used_o
);
  logic [SW-1:0]    sh_long;
  logic [WIN_W-1:0] long_f;
  logic [WIN_W-1:0] short_f;
  logic [WIN_W-1:0] u_ext;
  code_kind_e       kind;

  always_comb begin
    sh_long = SW'(WIN_W) - SW'(k_i);
    long_f  = window_i >> sh_long;
    short_f = long_f >> 1;  // top k-1 bits
    u_ext   = WIN_W'(u_i);
    if (k_i == '0)            kind = CODE_NONE;
    else if (short_f < u_ext) kind = CODE_SHORT;
    else                      kind = CODE_LONG;
  end

  always_comb begin
    unique case (kind)
      CODE_SHORT: begin
        value_o = VAL_W'(short_f);
        used_o  = USED_W'(k_i) - USED_W'(1);
      end
      CODE_LONG: begin
        value_o = VAL_W'(long_f - u_ext);
        used_o  = USED_W'(k_i);
      end
      default: begin
        value_o = '0;
        used_o  = '0;
      end
    endcase
  end
endmodule

// File: rtl/tbc_decoder.sv
module tbc_decoder #(
  parameter int unsigned VAL_W = tbc_pkg::DEF_VAL_W,
  parameter int unsigned WIN_W = tbc_pkg::DEF_WIN_W,
  localparam int unsigned KW = $clog2(VAL_W + 1),
  localparam int unsigned USED_W = $clog2(VAL_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [WIN_W-1:0]  window_i,
  input  logic [VAL_W-1:0]  limit_i,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [VAL_W-1:0]  value_o,
  output logic [USED_W-1:0] used_o
);
  logic [KW-1:0]     k_w;
  logic [VAL_W-1:0]  u_w;
  logic [VAL_W-1:0]  val_d;
  logic [USED_W-1:0] used_d;
  logic              valid_q;
  logic [VAL_W-1:0]  val_q;
  logic [USED_W-1:0] used_q;

  tbc_width #(.VAL_W(VAL_W)) u_width (
    .limit_i (limit_i),
    .k_o     (k_w)
  );

  tbc_thresh #(.VAL_W(VAL_W)) u_thresh (
    .limit_i (limit_i),
    .k_i     (k_w),
    .u_o     (u_w)
  );

  tbc_core #(.VAL_W(VAL_W), .WIN_W(WIN_W)) u_core (
    .window_i (window_i),
    .k_i      (k_w),
    .u_i      (u_w),
    .value_o  (val_d),
    .used_o   (used_d)
  );

  assign ready_o = !valid_q || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      val_q   <= '0;
      used_q  <= '0;
    end else if (valid_i && ready_o) begin
      valid_q <= 1'b1;
      val_q   <= val_d;
      used_q  <= used_d;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign value_o = val_q;
  assign used_o  = used_q;
endmodule

// File: rtl/tbc_decoder_chk.sv
module tbc_decoder_chk #(
  parameter int unsigned VAL_W = 16,
  parameter int unsigned WIN_W = 17,
  localparam int unsigned USED_W = $clog2(VAL_W + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              ready_o,
  input logic [WIN_W-1:0]  window_i,
  input logic [VAL_W-1:0]  limit_i,
  input logic              valid_o,
  input logic              ready_i,
  input logic [VAL_W-1:0]  value_o,
  input logic [USED_W-1:0] used_o
);
  logic [VAL_W-1:0] lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                lim_q <= '0;
    else if (valid_i && ready_o) lim_q <= limit_i;
  end

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> valid_o); // R6

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(value_o) && $stable(used_o)); // R7

  AST_STALL_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |-> !ready_o); // R7

  AST_ZERO_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && lim_q == '0 |-> value_o == '0 && used_o == '0); // R2

  AST_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> value_o <= lim_q && used_o <= USED_W'(VAL_W)); // R9
endmodule

bind tbc_decoder tbc_decoder_chk #(.VAL_W(VAL_W), .WIN_W(WIN_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .ready_o  (ready_o),
  .window_i (window_i),
  .limit_i  (limit_i),
  .valid_o  (valid_o),
  .ready_i  (ready_i),
  .value_o  (value_o),
  .used_o   (used_o)
);

// File: tb/tbc_decoder_test.sv
`timescale 1ns/1ps
module tbc_decoder_test;
  localparam int VAL_W = 16;
  localparam int WIN_W = 17;
  localparam int USED_W = $clog2(VAL_W + 1);
  localparam int NVEC = 14;

  // {limit, window, value, used}
  localparam logic [53:0] VEC [NVEC] = '{
    {16'd0,     17'h1FFFF, 16'd0,      5'd0},  // R2
    {16'd1,     17'h10000, 16'd1,      5'd1},  // R5
    {16'd7,     17'h14000, 16'd5,      5'd3},  // R5
    {16'd4,     17'h10000, 16'd2,      5'd2},  // R3
    {16'd4,     17'h1C000, 16'd4,      5'd3},  // R4
    {16'd4,     17'h18000, 16'd3,      5'd3},  // R4
    {16'd2,     17'h0FFFF, 16'd0,      5'd1},  // R3 R8
    {16'd2,     17'h10000, 16'd1,      5'd2},  // R4
    {16'd2,     17'h18000, 16'd2,      5'd2},  // R4
    {16'hFFFF,  17'h1579B, 16'hABCD,   5'd16}, // R5
    {16'hFFFE,  17'h00003, 16'd0,      5'd15}, // R3
    {16'hFFFE,  17'h1FFFF, 16'hFFFE,   5'd16}, // R4
    {16'd5,     17'h08000, 16'd1,      5'd2},  // R3
    {16'd5,     17'h10000, 16'd2,      5'd3}   // R4
  };

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              valid_i = 1'b0;
  logic              ready_o;
  logic [WIN_W-1:0]  window_i = '0;
  logic [VAL_W-1:0]  limit_i = '0;
  logic              valid_o;
  logic              ready_i = 1'b1;
  logic [VAL_W-1:0]  value_o;
  logic [USED_W-1:0] used_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tbc_decoder #(.VAL_W(VAL_W), .WIN_W(WIN_W)) uut (
    .clk_i (clk), .rst_ni (rst_ni), .valid_i (valid_i), .ready_o (ready_o),
    .window_i (window_i), .limit_i (limit_i), .valid_o (valid_o),
    .ready_i (ready_i), .value_o (value_o), .used_o (used_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference encoder: code bits and length for value x under limit m
  task automatic encode(input int m, input int x, output longint code, output int len,
                        output bit is_short);
    int n, k, u;
    n = m + 1;
    k = 0;
    while ((1 << k) < n) k++;
    u = (1 << k) - n;
    if (k == 0) begin code = 0; len = 0; is_short = 0; end
    else if (x < u) begin code = x; len = k - 1; is_short = 1; end
    else begin code = x + u; len = k; is_short = 0; end
  endtask

  task automatic run(input logic [VAL_W-1:0] m, input logic [WIN_W-1:0] win,
                     output logic [VAL_W-1:0] v, output logic [USED_W-1:0] u, output logic vo);
    @(negedge clk);
    limit_i = m; window_i = win; valid_i = 1'b1; ready_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    v = value_o; u = used_o; vo = valid_o;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [VAL_W-1:0]  v, a_val;
    logic [USED_W-1:0] u, a_used;
    logic              vo;

    // R1: reset state
    #1;
    check(valid_o == 1'b0, "R1 valid during reset", valid_o, 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(valid_o == 1'b0, "R1 valid after reset", valid_o, 0);
    check(ready_o == 1'b1, "R7 ready when empty", ready_o, 1);

    for (int i = 0; i < NVEC; i++) begin
      run(VEC[i][53:38], VEC[i][37:21], v, u, vo);
      check(vo == 1'b1, "R6 valid after accept", vo, 1);
      check(v == VEC[i][20:5], $sformatf("R3/R4 vec %0d value", i), v, VEC[i][20:5]);
      check(u == VEC[i][4:0], $sformatf("R3/R4 vec %0d used", i), u, VEC[i][4:0]);
    end

    // R6: drains when no new input
    @(negedge clk);
    check(valid_o == 1'b0, "R6 drain", valid_o, 0);

    // R2: zero limit ignores window content
    run('0, 17'h15555, v, u, vo);
    check(v == 0 && u == 0, "R2 zero limit", {v, u}, 0);

    // R8: random fill below the code must not matter; R3 R4 R5 random
    for (int t = 0; t < 600; t++) begin
      int m, x, len, bits;
      longint code, fill, win;
      bit sh;
      bits = (t % 16) + 1;
      m = int'($urandom) & ((1 << bits) - 1);
      x = int'($urandom % (m + 1));
      if (t % 7 == 0) m = (1 << bits) - 1;  // R5 power-of-two range
      if (x > m) x = m;
      encode(m, x, code, len, sh);
      fill = longint'($urandom) & ((64'd1 << (WIN_W - len)) - 1);
      win = (code << (WIN_W - len)) | fill;
      run(VAL_W'(m), WIN_W'(win), v, u, vo);
      if (sh) begin
        check(v == VAL_W'(x), "R3 R8 random value", v, x);
        check(u == USED_W'(len), "R3 random used", u, len);
      end else begin
        check(v == VAL_W'(x), "R4 R8 random value", v, x);
        check(u == USED_W'(len), "R4 random used", u, len);
      end
    end

    // R7: stall holds result and blocks input
    @(negedge clk);
    ready_i = 1'b0; limit_i = 16'd4; window_i = 17'h1C000; valid_i = 1'b1;
    @(negedge clk);
    limit_i = 16'd5; window_i = 17'h08000;
    check(valid_o == 1'b1 && value_o == 16'd4, "R7 first result", value_o, 4);
    a_val = value_o; a_used = used_o;
    repeat (3) begin
      @(negedge clk);
      check(ready_o == 1'b0, "R7 ready low in stall", ready_o, 0);
      check(value_o == a_val && used_o == a_used, "R7 hold", value_o, a_val);
    end
    ready_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    check(value_o == 16'd1 && used_o == 5'd2, "R7 next after release", value_o, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule